// File: doc/BRIEF.md
# Paged MDIO Register Access Bridge

This block lets a host reach 32-bit switch registers that sit behind a plain two-wire MDIO management bus. The host offers one request at a time, a read or a write with an 18-bit byte address and, for writes, 32 bits of data. The bridge derives three fields from the address: a 9-bit page, a 3-bit PHY-address suffix and a 5-bit even register index. It then runs a fixed series of clause-22 frames. The first frame loads the page into the page-select register. A programmable settle delay follows. Two 16-bit data frames then move the upper and lower halves.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole time an access is in flight, and a valid offered then is simply not taken. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse and `rsp_rdata` carries the result in that cycle, so the host must be ready to capture it. The MDIO data line is presented as separate output, output-enable and input signals, for a tri-state pad outside the block. MDC is produced by dividing the core clock.

Top module: `paged_mdio_bridge`

## Requirements
- R1: Register index = {addr[5:2], 0}, PHY suffix = addr[8:6], page = addr[17:9]; addr[1:0] has no effect on any frame or on the result.
- R2: Every access starts with a write frame to PHY address 5'h18, register 0, whose 16-bit data is the page zero-extended; exactly three frames are sent per access.
- R3: Between the last MDC rising edge of the page frame and the first MDC rising edge of the next frame there are at least SETTLE_CYCLES clock cycles, and no more than SETTLE_CYCLES + 4*CLK_DIV + 10.
- R4: Both data frames use PHY address 5'h10 OR the 3-bit suffix.
- R5: A read fetches register index first, then index+1, and returns {data(index+1), data(index)}.
- R6: A write sends addr data[31:16] to index+1 first, then data[15:0] to index.
- R7: Each frame is 64 MDC periods, sent MSB first: 32 ones, start 01, opcode 01 (write) or 10 (read), 5-bit PHY, 5-bit register, turnaround 10 on writes, 16 data bits.
- R8: In a read frame, mdio_oe is high for the first 46 bits and low from the turnaround through the last data bit. Read data is sampled while MDC is high.
- R9: req_ready is high only when idle. busy rises the cycle after acceptance and stays high through the rsp_valid cycle. Both return to idle levels the cycle after.
- R10: A request offered while busy is not accepted. It causes no frames and does not change the result of the access in flight.
- R11: After reset: busy=0, req_ready=1, rsp_valid=0, mdc=0, mdio_oe=0.
- R12: rsp_valid lasts exactly one cycle; rsp_rdata is 0 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address of the 32-bit register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result (0 for writes) |
| busy | output | 1 | Access in flight |
| mdc | output | 1 | Management clock, low when idle |
| mdio_o | output | 1 | Data value driven to the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_i | input | 1 | Data value seen at the pad |

## Verification
A sequencer stuck in the wrong state or holding the wrong latched address shows up right away in the decoded frames. The bench sees a wrong PHY or register field, halves in swapped order, or a missing page frame within the same access. The bench's model of the bus device mixes the current page into every read value. A page loaded late or with the wrong value therefore also corrupts `rsp_rdata` in that same response. A settle counter that ends early or late shows as a gap between the page frame and the first data frame that falls outside the window. An output-enable that is held too long, or shifted data that is misaligned, corrupts the data bits of the very frame involved.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
  localparam int ADDR_W   = 18;
  localparam int FRAME_N  = 64;
  localparam int PREAMBLE = 32;
  localparam int TA_BIT   = 46;
  localparam int DATA_BIT = 48;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef struct packed {
    logic [8:0] page;
    logic [2:0] sfx;
    logic [4:0] idx;
  } pmb_addr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PAGE, S_SETTLE, S_HALF1, S_HALF2, S_RESP
  } pmb_state_e;
endpackage

// File: rtl/pmb_addr_split.sv
module pmb_addr_split
  import pmb_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output pmb_addr_t         fields
);
  always_comb begin
    fields.idx  = {addr[5:2], 1'b0};
    fields.sfx  = addr[8:6];
    fields.page = addr[17:9];
  end
endmodule

// File: rtl/pmb_mdio_master.sv
module pmb_mdio_master
  import pmb_pkg::*;
#(
  parameter int CLK_DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wr,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int PH_W = (2 * CLK_DIV > 1) ? $clog2(2 * CLK_DIV) : 1;
  localparam logic [PH_W-1:0] PH_HI   = PH_W'(CLK_DIV);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * CLK_DIV - 1);
  localparam logic [5:0] LAST_BIT = 6'(FRAME_N - 1);

  logic              run, rd_q, done_q;
  logic [63:0]       shreg;
  logic [5:0]        bitn;
  logic [PH_W-1:0]   phase;
  logic [15:0]       rdata_q;
  logic [63:0]       frame;

  always_comb begin
    frame = {{PREAMBLE{1'b1}}, 2'b01, (wr ? OP_WR : OP_RD), phy, regad,
             (wr ? 2'b10 : 2'b11), (wr ? wdata : 16'hFFFF)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      shreg   <= '1;
      bitn    <= '0;
      phase   <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        if (start) begin
          run   <= 1'b1;
          rd_q  <= !wr;
          shreg <= frame;
          bitn  <= '0;
          phase <= '0;
        end
      end else begin
        if (rd_q && phase == PH_HI && bitn >= 6'(DATA_BIT))
          rdata_q <= {rdata_q[14:0], mdio_i};
        if (phase == PH_LAST) begin
          phase <= '0;
          shreg <= {shreg[62:0], 1'b1};
          if (bitn == LAST_BIT) begin
            run    <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bitn <= bitn + 6'd1;
          end
        end else begin
          phase <= phase + PH_W'(1);
        end
      end
    end
  end

  assign mdc     = run && (phase >= PH_HI);
  assign mdio_o  = shreg[63];
  assign mdio_oe = run && !(rd_q && bitn >= 6'(TA_BIT));
  assign busy    = run;
  assign done    = done_q;
  assign rdata   = rdata_q;

  // R7: a frame only ends after its last bit
  assert_frame_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> bitn == LAST_BIT);
  // R9: the sequencer never starts a frame over a running one
  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run);
  // R12: completion is a single pulse
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/pmb_seq.sv
module pmb_seq
  import pmb_pkg::*;
#(
  parameter int          SETTLE_CYCLES = 200000,
  parameter logic [4:0]  PAGE_PHY      = 5'h18,
  parameter logic [4:0]  DATA_PHY_BASE = 5'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  pmb_addr_t   req_fields,
  input  logic [31:0] req_wdata,
  output logic        req_ready,
  output logic        busy,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  input  logic        m_busy,
  input  logic        m_done,
  input  logic [15:0] m_rdata,
  output logic        m_start,
  output logic        m_wr,
  output logic [4:0]  m_phy,
  output logic [4:0]  m_reg,
  output logic [15:0] m_wdata
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE_CYCLES - 1);

  pmb_state_e       state;
  pmb_addr_t        lat;
  logic             we_q, sent;
  logic [31:0]      wd_q, rd_q;
  logic [CNT_W-1:0] cnt;
  logic [4:0]       data_phy, reg_odd;

  assign data_phy = DATA_PHY_BASE | {2'b00, lat.sfx};
  assign reg_odd  = {lat.idx[4:1], 1'b1};

  always_comb begin
    m_start = 1'b0;
    m_wr    = 1'b1;
    m_phy   = PAGE_PHY;
    m_reg   = 5'd0;
    m_wdata = {7'd0, lat.page};
    unique case (state)
      S_PAGE: m_start = !sent && !m_busy;
      S_HALF1: begin
        m_start = !sent && !m_busy;
        m_wr    = we_q;
        m_phy   = data_phy;
        m_reg   = we_q ? reg_odd : lat.idx;
        m_wdata = wd_q[31:16];
      end
      S_HALF2: begin
        m_start = !sent && !m_busy;
        m_wr    = we_q;
        m_phy   = data_phy;
        m_reg   = we_q ? lat.idx : reg_odd;
        m_wdata = wd_q[15:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      lat   <= '0;
      we_q  <= 1'b0;
      wd_q  <= '0;
      rd_q  <= '0;
      sent  <= 1'b0;
      cnt   <= '0;
    end else begin
      if (m_start) sent <= 1'b1;
      unique case (state)
        S_IDLE: if (req_valid) begin
          lat   <= req_fields;
          we_q  <= req_write;
          wd_q  <= req_wdata;
          rd_q  <= '0;
          sent  <= 1'b0;
          state <= S_PAGE;
        end
        S_PAGE: if (m_done) begin
          sent  <= 1'b0;
          cnt   <= '0;
          state <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt == CNT_END) state <= S_HALF1;
          else cnt <= cnt + CNT_W'(1);
        end
        S_HALF1: if (m_done) begin
          sent  <= 1'b0;
          if (!we_q) rd_q[15:0] <= m_rdata;
          state <= S_HALF2;
        end
        S_HALF2: if (m_done) begin
          sent  <= 1'b0;
          if (!we_q) rd_q[31:16] <= m_rdata;
          state <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign rsp_rdata = rd_q;

  // R9: once busy, stays busy until the response cycle
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rsp_valid |=> busy);
  // R12: response is a single-cycle pulse
  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && !busy);
  // R10: latched request cannot change while an access is in flight
  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rsp_valid |=> $stable(lat) && $stable(we_q) && $stable(wd_q));
  // R3: data phase is entered only after the full settle count
  assert_settle_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_HALF1 && $past(state) == S_SETTLE |-> $past(cnt) == CNT_END);
  // R12: a write returns zero
  assert_wr_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && we_q |-> rsp_rdata == 32'd0);
endmodule

// File: rtl/paged_mdio_bridge.sv
module paged_mdio_bridge
  import pmb_pkg::*;
#(
  parameter int         CLK_DIV       = 20,
  parameter int         SETTLE_CYCLES = 200000,
  parameter logic [4:0] PAGE_PHY      = 5'h18,
  parameter logic [4:0] DATA_PHY_BASE = 5'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [17:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  pmb_addr_t   fields;
  logic        m_start, m_wr, m_busy, m_done;
  logic [4:0]  m_phy, m_reg;
  logic [15:0] m_wdata, m_rdata;

  pmb_addr_split u_split (
    .addr   (req_addr),
    .fields (fields)
  );

  pmb_seq #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .PAGE_PHY      (PAGE_PHY),
    .DATA_PHY_BASE (DATA_PHY_BASE)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_fields (fields),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .m_busy     (m_busy),
    .m_done     (m_done),
    .m_rdata    (m_rdata),
    .m_start    (m_start),
    .m_wr       (m_wr),
    .m_phy      (m_phy),
    .m_reg      (m_reg),
    .m_wdata    (m_wdata)
  );

  pmb_mdio_master #(
    .CLK_DIV (CLK_DIV)
  ) u_mdio (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (m_start),
    .wr      (m_wr),
    .phy     (m_phy),
    .regad   (m_reg),
    .wdata   (m_wdata),
    .busy    (m_busy),
    .done    (m_done),
    .rdata   (m_rdata),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .mdio_i  (mdio_i)
  );

  // R11: bus quiet whenever no access is in flight
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc && !mdio_oe);
  // R9: ready and busy are never high together
  assert_ready_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && busy));
endmodule

// File: tb/paged_mdio_bridge_tb_top.sv
`timescale 1ns/1ps
module paged_mdio_bridge_tb_top;
  localparam int DIV = 2;
  localparam int SET = 40;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, busy, mdc, mdio_o, mdio_oe;
  logic [31:0] rsp_rdata;
  logic mdio_i = 1'b1;

  always #2.5 clk = ~clk;

  paged_mdio_bridge #(.CLK_DIV(DIV), .SETTLE_CYCLES(SET)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] slave_val(input logic [8:0] pg, input logic [4:0] ph, input logic [4:0] rg);
    logic [15:0] t;
    t = {7'd0, pg} * 16'h003b;
    t = t ^ ({6'd0, ph, rg} * 16'h01d9);
    return t ^ 16'h5a3c;
  endfunction

  // ---- bus device model ----
  logic [63:0] sh = '1;
  int bitpos = 0, nfr = 0, t0 = 0;
  bit rd_act = 0, oe_bad = 0;
  logic [15:0] cur_rd = '0;
  logic [8:0] cur_page = '0;
  logic [1:0]  f_op [0:511];
  logic [4:0]  f_phy[0:511];
  logic [4:0]  f_reg[0:511];
  logic [15:0] f_dat[0:511];
  bit          f_fmt[0:511];
  bit          f_oe [0:511];
  int          f_t0 [0:511];
  int          f_t63[0:511];

  always @(posedge mdc) begin
    logic b;
    b = mdio_oe ? mdio_o : mdio_i;
    if (bitpos == 0) begin t0 = cyc; oe_bad = 0; end
    if (bitpos < 46 && !mdio_oe) oe_bad = 1;
    if (bitpos >= 46 && rd_act && mdio_oe) oe_bad = 1;
    if (bitpos >= 46 && !rd_act && !mdio_oe) oe_bad = 1;
    sh = {sh[62:0], b};
    if (bitpos == 45) begin
      rd_act = (sh[11:10] == 2'b10);
      if (rd_act) cur_rd = slave_val(cur_page, sh[9:5], sh[4:0]);
    end
    if (bitpos == 63) begin
      if (nfr < 512) begin
        f_op[nfr]  = sh[29:28];
        f_phy[nfr] = sh[27:23];
        f_reg[nfr] = sh[22:18];
        f_dat[nfr] = sh[15:0];
        f_fmt[nfr] = (sh[63:32] == 32'hFFFF_FFFF) && (sh[31:30] == 2'b01) &&
                     ((sh[29:28] == 2'b01 && sh[17:16] == 2'b10) || sh[29:28] == 2'b10);
        f_oe[nfr]  = !oe_bad;
        f_t0[nfr]  = t0;
        f_t63[nfr] = cyc;
      end
      if (sh[29:28] == 2'b01 && sh[27:23] == 5'h18 && sh[22:18] == 5'd0) cur_page = sh[8:0];
      nfr++;
      bitpos = 0;
      rd_act = 0;
    end else bitpos++;
  end

  always @(negedge mdc) begin
    if (rd_act && bitpos == 47) mdio_i = 1'b0;
    else if (rd_act && bitpos >= 48) mdio_i = cur_rd[63 - bitpos];
    else mdio_i = 1'b1;
  end

  // ---- one access ----
  task automatic txn(input bit we, input logic [17:0] a, input logic [31:0] wd, input bit poke);
    int base, w, gap;
    logic [31:0] got, exp;
    logic [4:0] idx, dphy;
    logic [8:0] pg;
    idx  = {a[5:2], 1'b0};          // R1 split
    dphy = {2'b10, a[8:6]};
    pg   = a[17:9];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    base = nfr;
    req_valid = 1; req_write = we; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1'b1, "R9 busy after accept", {31'd0, busy}, 1);
    chk(req_ready == 1'b0, "R9 ready low while busy", {31'd0, req_ready}, 0);
    if (poke) begin
      repeat (30) @(negedge clk);
      req_valid = 1; req_write = ~we; req_addr = ~a; req_wdata = ~wd;
      repeat (150) @(negedge clk);
      chk(req_ready == 1'b0, "R10 request not taken while busy", {31'd0, req_ready}, 0);
      req_valid = 0;
    end
    w = 0;
    while (!rsp_valid && w < 20000) begin @(negedge clk); w++; end
    got = rsp_rdata;
    chk(busy == 1'b1, "R9 busy in response cycle", {31'd0, busy}, 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12 single-cycle response", {31'd0, rsp_valid}, 0);
    chk(busy == 1'b0 && req_ready == 1'b1, "R9 idle after response", {30'd0, busy, req_ready}, 1);
    chk(nfr - base == 3, poke ? "R10 frame count with busy request" : "R2 frame count", nfr - base, 3);
    if (nfr - base != 3 || base + 2 >= 512) return;
    // page frame
    chk(f_op[base] == 2'b01 && f_phy[base] == 5'h18 && f_reg[base] == 0, "R2 page frame header",
        {f_op[base], f_phy[base], f_reg[base]}, {2'b01, 5'h18, 5'd0});
    chk(f_dat[base] == {7'd0, pg}, "R2 page value", f_dat[base], {7'd0, pg});
    gap = f_t0[base+1] - f_t63[base];
    chk(gap >= SET && gap <= SET + 4*DIV + 10, "R3 settle gap", gap, SET);
    for (int k = 0; k < 3; k++) begin
      chk(f_fmt[base+k], "R7 frame format", k, 0);
      chk(f_oe[base+k], "R8 output enable pattern", k, 0);
    end
    chk(f_phy[base+1] == dphy && f_phy[base+2] == dphy, "R4 data phy", {f_phy[base+1], f_phy[base+2]}, {dphy, dphy});
    if (we) begin
      chk(f_op[base+1] == 2'b01 && f_op[base+2] == 2'b01, "R7 write opcode", {f_op[base+1], f_op[base+2]}, 4'b0101);
      chk(f_reg[base+1] == (idx | 5'd1) && f_dat[base+1] == wd[31:16], "R6 high half first",
          {f_reg[base+1], f_dat[base+1]}, {idx | 5'd1, wd[31:16]});
      chk(f_reg[base+2] == idx && f_dat[base+2] == wd[15:0], "R6 low half second",
          {f_reg[base+2], f_dat[base+2]}, {idx, wd[15:0]});
      chk(got == 0, "R12 write result zero", got, 0);
    end else begin
      chk(f_op[base+1] == 2'b10 && f_op[base+2] == 2'b10, "R7 read opcode", {f_op[base+1], f_op[base+2]}, 4'b1010);
      chk(f_reg[base+1] == idx && f_reg[base+2] == (idx | 5'd1), "R5 read order", {f_reg[base+1], f_reg[base+2]}, {idx, idx | 5'd1});
      exp = {slave_val(pg, dphy, idx | 5'd1), slave_val(pg, dphy, idx)};
      chk(got == exp, "R5 R8 assembled read data", got, exp);
    end
  endtask

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    #1;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk(busy == 0 && req_ready == 1 && rsp_valid == 0 && mdc == 0 && mdio_oe == 0,
        "R11 reset outputs", {27'd0, busy, req_ready, rsp_valid, mdc, mdio_oe}, 5'b01000);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && req_ready == 1 && mdc == 0 && mdio_oe == 0,
        "R11 idle after reset", {28'd0, busy, req_ready, mdc, mdio_oe}, 4'b0100);
    // directed corners
    txn(0, 18'h00000, 32'h0, 0);
    txn(0, 18'h3FFFF, 32'h0, 0);
    txn(1, 18'h3FFFC, 32'hDEAD_BEEF, 0);
    txn(0, 18'h12345, 32'h0, 0);
    txn(0, 18'h12346, 32'h0, 0);       // R1: differs only in addr[1:0]
    txn(1, 18'h001C0, 32'h8000_0001, 1); // R10: offer during busy
    txn(0, 18'h2A5A8, 32'h0, 1);
    // random mix
    for (int i = 0; i < 30; i++) begin
      bit we;
      logic [17:0] a;
      logic [31:0] d;
      we = $urandom() % 2;
      a  = 18'($urandom());
      d  = $urandom();
      txn(we, a, d, (i % 7) == 3);
    end
    // R10: nothing more on the bus once idle
    begin
      int n0;
      n0 = nfr;
      repeat (600) @(negedge clk);
      chk(nfr == n0 && mdc == 0, "R10 no stray frames", nfr, n0);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule